// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical position counters of a raster display, together with blanking, sync and display-enable flags. Every boundary of a frame is held in 32-bit configuration words. Each word packs two boundaries, and every boundary is stored as its count minus one. A second pair of words gives separate sync windows for a flat-panel output. This lets the panel's vertical sync run one line ahead of the main vertical sync.

Software programs the block through a simple word-addressed write port, and can read any word back through a separate read port. Writing a fixed key to the unlock word opens the configuration words. While the block is locked, writes to any other word are dropped. A control word turns on the counters, the blanking and display-enable flags, each main sync output, and the flat-panel sync pair.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset, every configuration word and the unlock word read back as zero. Both counters are zero, every output flag is low, and the block is locked.
- R2: A write to word 1..9 is stored only while the unlock word (address 0) holds 0x00004758. When the word holds any other value, such a write is dropped and the readback of the target word is unchanged.
- R3: The unlock word itself is always writable. Writing 0, or any value other than 0x00004758, locks the block again.
- R4: In each timing word, bits [15:0] hold the first boundary minus one and bits [31:16] hold the second boundary minus one. A stored word reads back exactly as written. The address map is: 2 holds h active/total, 3 holds h blank start/end, 4 holds h sync start/end, 5 holds v active/total, 6 holds v blank start/end, 7 holds v sync start/end, 8 holds panel h sync start/end, and 9 holds panel v sync start/end.
- R5: While the generator runs, the horizontal counter advances by one each clock. It returns to 0 on the clock after it reaches or exceeds word 2 bits [31:16].
- R6: The vertical counter advances by one only on a clock where the horizontal counter returns to 0. It returns to 0 in place of stepping past word 5 bits [31:16].
- R7: Control word 1 has five enables: bit 0 runs the counters, bit 1 enables blanking and display enable, bit 2 enables hsync, bit 3 enables vsync, and bit 4 enables the panel syncs. While bit 0 is clear, both counters are held at 0 and every output flag is low.
- R8: hsync_o is high when the horizontal count c satisfies lo <= c < hi for word 4 and control bit 2 is set. vsync_o follows the same rule with word 7 and control bit 3. Both are active-high.
- R9: blank_o is high when control bit 1 is set and, on either axis, the count c satisfies lo < c <= hi for that axis's blank word (3 or 6).
- R10: de_o is high when control bit 1 is set, the horizontal count is <= word 2 bits [15:0], and the vertical count is <= word 5 bits [15:0].
- R11: fp_hsync_o and fp_vsync_o apply the R8 window rule to words 8 and 9, gated by control bit 4.
- R12: A write at a clock edge changes the readback and the output flags right after that edge. The counters use the control and total values that were in force before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 4 | Word address for writes |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 4 | Word address for reads |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| h_count_o | output | 12 | Horizontal position |
| v_count_o | output | 12 | Vertical position |
| blank_o | output | 1 | Blanking flag |
| de_o | output | 1 | Display enable |
| hsync_o | output | 1 | Main horizontal sync |
| vsync_o | output | 1 | Main vertical sync |
| fp_hsync_o | output | 1 | Panel horizontal sync |
| fp_vsync_o | output | 1 | Panel vertical sync |

## Verification
The only state in the block is the counters and the stored words. Every flag and the read data are combinational from that state, so a write or a counter step at edge k is visible at the ports during the rest of cycle k. The bench applies each stimulus at a falling edge and advances a behavioural model of words and counters at the next rising edge. The model uses the pre-edge control and total values, as R12 requires. The bench then compares all counters and flags at the following falling edge, which places every comparison half a cycle after the update it checks. Readback checks set the read address between edges and sample after a short settle delay.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int unsigned FLD_W    = 16;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned N_WORDS  = 10;
  localparam int unsigned ADDR_W   = 4;
  localparam logic [WORD_W-1:0] UNLOCK_KEY = 32'h0000_4758;

  localparam int unsigned IX_UNLOCK = 0;
  localparam int unsigned IX_CTRL   = 1;
  localparam int unsigned IX_H_ACT  = 2;
  localparam int unsigned IX_H_BLK  = 3;
  localparam int unsigned IX_H_SYN  = 4;
  localparam int unsigned IX_V_ACT  = 5;
  localparam int unsigned IX_V_BLK  = 6;
  localparam int unsigned IX_V_SYN  = 7;
  localparam int unsigned IX_FP_H   = 8;
  localparam int unsigned IX_FP_V   = 9;

  typedef struct packed {
    logic [FLD_W-1:0] hi;
    logic [FLD_W-1:0] lo;
  } pair_t;

  // bit order matches control word bits [4:0]
  typedef struct packed {
    logic fp_en;
    logic vs_en;
    logic hs_en;
    logic blank_en;
    logic gen_en;
  } ctrl_t;

  typedef struct packed {
    pair_t act;
    pair_t blk;
    pair_t syn;
  } axis_t;

  typedef struct packed {
    ctrl_t ctrl;
    axis_t h;
    axis_t v;
    pair_t fp_h;
    pair_t fp_v;
  } cfg_t;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int unsigned NW = N_WORDS,
  parameter int unsigned AW = ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output cfg_t              cfg_o,
  output logic              unlocked_o
);
  logic [WORD_W-1:0] word_q [NW];

  assign unlocked_o = (word_q[IX_UNLOCK] == UNLOCK_KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int unsigned i = 0; i < NW; i++) word_q[i] <= '0;
    end else begin
      for (int unsigned i = 0; i < NW; i++) begin
        // unlock word always open; others gated by key
        if (wr_en_i && wr_addr_i == AW'(i) && (i == IX_UNLOCK || unlocked_o))
          word_q[i] <= wr_data_i;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int unsigned i = 0; i < NW; i++)
      if (rd_addr_i == AW'(i)) rd_data_o = word_q[i];
  end

  always_comb begin
    cfg_o.ctrl  = ctrl_t'(word_q[IX_CTRL][4:0]);
    cfg_o.h.act = pair_t'(word_q[IX_H_ACT]);
    cfg_o.h.blk = pair_t'(word_q[IX_H_BLK]);
    cfg_o.h.syn = pair_t'(word_q[IX_H_SYN]);
    cfg_o.v.act = pair_t'(word_q[IX_V_ACT]);
    cfg_o.v.blk = pair_t'(word_q[IX_V_BLK]);
    cfg_o.v.syn = pair_t'(word_q[IX_V_SYN]);
    cfg_o.fp_h  = pair_t'(word_q[IX_FP_H]);
    cfg_o.fp_v  = pair_t'(word_q[IX_FP_V]);
  end

  p_locked_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !unlocked_o && wr_addr_i != AW'(IX_UNLOCK)) |=> $stable(cfg_o));

  p_relock_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == AW'(IX_UNLOCK) && wr_data_i != UNLOCK_KEY) |=> !unlocked_o);

  p_store_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && unlocked_o && wr_addr_i == AW'(IX_H_ACT)) |=> (cfg_o.h.act == $past(wr_data_i)));
endmodule

// File: rtl/rtg_counter.sv
module rtg_counter #(
  parameter int unsigned CW = 12,
  parameter int unsigned FW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          step_i,
  input  logic [FW-1:0] last_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q;
  logic          at_end;

  // >= so a shrunk total cannot strand the count above it
  assign at_end = (FW'(cnt_q) >= last_i);
  assign wrap_o = step_i && at_end;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (step_i)  cnt_q <= at_end ? '0 : cnt_q + CW'(1);
  end

  p_halt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_o == '0));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !step_i) |=> $stable(cnt_o));

  p_advance_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && step_i && !at_end) |=> (cnt_o == $past(cnt_o) + CW'(1)));
endmodule

// File: rtl/rtg_window.sv
module rtg_window #(
  parameter int unsigned FW      = 16,
  parameter bit          OPEN_LO = 1'b0
) (
  input  logic [FW-1:0] cnt_i,
  input  logic [FW-1:0] lo_i,
  input  logic [FW-1:0] hi_i,
  output logic          in_o
);
  if (OPEN_LO) begin : g_blank
    assign in_o = (cnt_i > lo_i) && (cnt_i <= hi_i);
  end else begin : g_sync
    assign in_o = (cnt_i >= lo_i) && (cnt_i < hi_i);
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  h_count_o,
  output logic [CNT_W-1:0]  v_count_o,
  output logic              blank_o,
  output logic              de_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              fp_hsync_o,
  output logic              fp_vsync_o
);
  localparam int unsigned N_WIN   = 6;
  localparam int unsigned W_HS    = 0;
  localparam int unsigned W_VS    = 1;
  localparam int unsigned W_FPH   = 2;
  localparam int unsigned W_FPV   = 3;
  localparam int unsigned W_HB    = 4;
  localparam int unsigned W_VB    = 5;
  localparam int unsigned FIRST_B = W_HB;

  cfg_t cfg;
  logic unlocked;
  logic run, h_wrap, v_wrap;
  logic [FLD_W-1:0] h_ext, v_ext;
  logic [FLD_W-1:0] win_cnt [N_WIN];
  logic [FLD_W-1:0] win_lo  [N_WIN];
  logic [FLD_W-1:0] win_hi  [N_WIN];
  logic [N_WIN-1:0] win_in;

  rtg_regs #(.NW(N_WORDS), .AW(ADDR_W)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o),
    .cfg_o      (cfg),
    .unlocked_o (unlocked)
  );

  assign run = cfg.ctrl.gen_en;

  rtg_counter #(.CW(CNT_W), .FW(FLD_W)) i_hcnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .step_i (1'b1),
    .last_i (cfg.h.act.hi),
    .cnt_o  (h_count_o),
    .wrap_o (h_wrap)
  );

  rtg_counter #(.CW(CNT_W), .FW(FLD_W)) i_vcnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .step_i (h_wrap),
    .last_i (cfg.v.act.hi),
    .cnt_o  (v_count_o),
    .wrap_o (v_wrap)
  );

  assign h_ext = FLD_W'(h_count_o);
  assign v_ext = FLD_W'(v_count_o);

  always_comb begin
    win_cnt[W_HS]  = h_ext; win_lo[W_HS]  = cfg.h.syn.lo; win_hi[W_HS]  = cfg.h.syn.hi;
    win_cnt[W_VS]  = v_ext; win_lo[W_VS]  = cfg.v.syn.lo; win_hi[W_VS]  = cfg.v.syn.hi;
    win_cnt[W_FPH] = h_ext; win_lo[W_FPH] = cfg.fp_h.lo;  win_hi[W_FPH] = cfg.fp_h.hi;
    win_cnt[W_FPV] = v_ext; win_lo[W_FPV] = cfg.fp_v.lo;  win_hi[W_FPV] = cfg.fp_v.hi;
    win_cnt[W_HB]  = h_ext; win_lo[W_HB]  = cfg.h.blk.lo; win_hi[W_HB]  = cfg.h.blk.hi;
    win_cnt[W_VB]  = v_ext; win_lo[W_VB]  = cfg.v.blk.lo; win_hi[W_VB]  = cfg.v.blk.hi;
  end

  // sync windows are half-open at the top, blank windows at the bottom
  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    rtg_window #(.FW(FLD_W), .OPEN_LO(w >= FIRST_B)) i_win (
      .cnt_i (win_cnt[w]),
      .lo_i  (win_lo[w]),
      .hi_i  (win_hi[w]),
      .in_o  (win_in[w])
    );
  end

  logic act_h, act_v;
  assign act_h = (h_ext <= cfg.h.act.lo);
  assign act_v = (v_ext <= cfg.v.act.lo);

  assign blank_o    = run && cfg.ctrl.blank_en && (win_in[W_HB] || win_in[W_VB]);
  assign de_o       = run && cfg.ctrl.blank_en && act_h && act_v;
  assign hsync_o    = run && cfg.ctrl.hs_en && win_in[W_HS];
  assign vsync_o    = run && cfg.ctrl.vs_en && win_in[W_VS];
  assign fp_hsync_o = run && cfg.ctrl.fp_en && win_in[W_FPH];
  assign fp_vsync_o = run && cfg.ctrl.fp_en && win_in[W_FPV];

  p_v_per_line_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !h_wrap) |=> $stable(v_count_o));

  p_frame_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && h_wrap && v_wrap) |=> (v_count_o == '0 && h_count_o == '0));

  p_locked_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked && !run) |=> (h_count_o == '0));
endmodule

// File: tb/test_raster_timing_gen.sv
`timescale 1ns/1ps
module test_raster_timing_gen;
  localparam logic [31:0] KEY = 32'h0000_4758;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [11:0] h_cnt, v_cnt;
  logic        blank, de, hs, vs, fph, fpv;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] m_reg [10];
  int mh = 0;
  int mv = 0;

  always #5 clk = ~clk;

  raster_timing_gen i_raster_timing_gen (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .h_count_o(h_cnt), .v_count_o(v_cnt), .blank_o(blank), .de_o(de),
    .hsync_o(hs), .vsync_o(vs), .fp_hsync_o(fph), .fp_vsync_o(fpv)
  );

  function automatic bit in_sync(int c, logic [31:0] w);
    return (c >= int'(w[15:0])) && (c < int'(w[31:16]));
  endfunction

  function automatic bit in_blank(int c, logic [31:0] w);
    return (c > int'(w[15:0])) && (c <= int'(w[31:16]));
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%08h exp=%08h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pack_dut();
    return {2'b0, h_cnt, v_cnt, blank, de, hs, vs, fph, fpv};
  endfunction

  function automatic logic [31:0] pack_model();
    logic [4:0] c;
    logic b, d, s1, s2, s3, s4;
    c  = m_reg[1][4:0];
    b  = c[0] && c[1] && (in_blank(mh, m_reg[3]) || in_blank(mv, m_reg[6]));
    d  = c[0] && c[1] && (mh <= int'(m_reg[2][15:0])) && (mv <= int'(m_reg[5][15:0]));
    s1 = c[0] && c[2] && in_sync(mh, m_reg[4]);
    s2 = c[0] && c[3] && in_sync(mv, m_reg[7]);
    s3 = c[0] && c[4] && in_sync(mh, m_reg[8]);
    s4 = c[0] && c[4] && in_sync(mv, m_reg[9]);
    return {2'b0, 12'(mh), 12'(mv), b, d, s1, s2, s3, s4};
  endfunction

  // called at a falling edge; compares at the next falling edge
  task automatic tick(bit we, logic [3:0] a, logic [31:0] d);
    bit en;
    wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    en = m_reg[1][0];
    if (!en) begin
      mh = 0; mv = 0;
    end else if (mh >= int'(m_reg[2][31:16])) begin
      mh = 0;
      if (mv >= int'(m_reg[5][31:16])) mv = 0; else mv++;
    end else mh++;
    if (we) begin
      if (a == 4'd0) m_reg[0] = d;
      else if (a < 4'd10 && m_reg[0] == KEY) m_reg[a] = d;
    end
    @(negedge clk);
    wr_en = 1'b0;
    check(pack_dut() == pack_model(), "R5 R6 R7 R8 R9 R10 R11 R12 cycle", pack_dut(), pack_model());
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(0, 4'd0, 32'd0);
  endtask

  task automatic check_rd(logic [3:0] a, logic [31:0] exp, string req);
    rd_addr = a;
    #1;
    check(rd_data == exp, req, rd_data, exp);
  endtask

  initial begin
    for (int i = 0; i < 10; i++) m_reg[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(pack_dut() == 32'd0, "R1 outputs", pack_dut(), 32'd0);
    for (int i = 0; i < 10; i++) check_rd(4'(i), 32'd0, "R1 readback");
    rst_n = 1'b1;
    @(negedge clk);

    // R2: locked writes are dropped
    tick(1, 4'd1, 32'h1F);
    check_rd(4'd1, 32'd0, "R2 locked ctrl");
    tick(1, 4'd2, 32'h000F_0007);
    check_rd(4'd2, 32'd0, "R2 locked h word");
    tick(1, 4'd0, KEY);
    check_rd(4'd0, KEY, "R2 key stored");

    // R4: program mode A (8 active, total 16; 4 lines, total 9)
    tick(1, 4'd2, 32'h000F_0007); check_rd(4'd2, 32'h000F_0007, "R4 h act");
    tick(1, 4'd3, 32'h000F_0007);
    tick(1, 4'd4, 32'h000C_0009); check_rd(4'd4, 32'h000C_0009, "R4 h sync");
    tick(1, 4'd5, 32'h0008_0003);
    tick(1, 4'd6, 32'h0008_0003);
    tick(1, 4'd7, 32'h0006_0004);
    tick(1, 4'd8, 32'h000C_0009);
    tick(1, 4'd9, 32'h0005_0003); check_rd(4'd9, 32'h0005_0003, "R4 fp v");
    tick(1, 4'd1, 32'h1F);
    check(h_cnt == 12'd0, "R12 counters wait for enable edge", 32'(h_cnt), 32'd0);
    idle(1);
    check(h_cnt == 12'd1, "R5 first step", 32'(h_cnt), 32'd1);
    idle(320);

    // partial enables
    tick(1, 4'd1, 32'h05); idle(160);
    tick(1, 4'd1, 32'h1B); idle(160);

    // R12: mode change while running (total 20)
    tick(1, 4'd2, 32'h0013_0009);
    tick(1, 4'd3, 32'h0013_0009);
    tick(1, 4'd4, 32'h000F_000B);
    tick(1, 4'd1, 32'h1F);
    idle(260);

    // R7: stop generator
    tick(1, 4'd1, 32'h1E);
    idle(5);
    check(h_cnt == 12'd0 && v_cnt == 12'd0, "R7 halted counters", {h_cnt, v_cnt}, 32'd0);
    check(!(blank || de || hs || vs || fph || fpv), "R7 flags low", pack_dut(), 32'd0);

    // R3: relock with 0, then with a wrong key
    tick(1, 4'd0, 32'd0);
    tick(1, 4'd1, 32'h1F);
    check_rd(4'd1, 32'h1E, "R3 relocked by zero");
    tick(1, 4'd0, KEY);
    tick(1, 4'd0, KEY + 32'd1);
    tick(1, 4'd2, 32'h0);
    check_rd(4'd2, 32'h0013_0009, "R3 relocked by wrong key");
    idle(4);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule